// File: doc/BRIEF.md
# GPIO Port Register Bank with Bit-Operation Aliases

This block is the software-visible register bank of a 16-pin general-purpose I/O port. It stores the port data word, two interrupt mask words, and five per-pin configuration words: direction, sense polarity, edge select, both-edge select and input enable. The pad-side logic and a separate interrupt detector read the stored words from the block's outputs. Pin sampling, interrupt detection and pad electrical behaviour are handled elsewhere.

The data word and each mask word can be written in four ways. A plain write replaces the word. Three alias addresses clear, set or toggle only the bits written as 1, so software can change single pins without a read-modify-write. A read of an alias returns the word it modifies. Every access must be 16 bits wide. A bad access raises a one-cycle error flag together with a code, and a wrong size is reported ahead of a bad address. An output pin's driven value changes only when the pin is an output and its data bit actually changes, so turning a pin into an output does not by itself refresh its driven value.

Top module: `gpio_regbank`

## Requirements
- R1: After reset every stored word is zero, and `pin_out`, `pin_dir`, all configuration outputs, `bus_rdata`, `bus_err` and `bus_err_code` are zero.
- R2: A legal write replaces the whole word at these byte offsets: data 0x00, mask A 0x10, mask B 0x20, direction 0x30, polarity 0x34, edge 0x38, both-edge 0x3C, input enable 0x40. Reads at these offsets return the stored word.
- R3: A write to base+0x04 of the data, mask A or mask B word (offsets 0x04, 0x14, 0x24) clears each bit of that word where the written bit is 1 and leaves the others.
- R4: A write to base+0x08 (offsets 0x08, 0x18, 0x28) ORs the written value into the word.
- R5: A write to base+0x0C (offsets 0x0C, 0x1C, 0x2C) XORs the written value into the word.
- R6: A read of any clear, set or toggle alias returns the current value of the word it modifies.
- R7: `bus_size` encodes 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved. Only 1 is legal; any other size gives `bus_err_code` = 1 whatever the address.
- R8: An offset above 0x40, or one that is not a multiple of 4, gives `bus_err_code` = 2 when the size is legal. `bus_err_code` is 0 for a legal access.
- R9: An access that raises an error changes no stored word, and an errored read returns 0 on `bus_rdata`.
- R10: `pin_out` bit i takes the new data bit i only in a write cycle where direction bit i (after the write) is 1 and data bit i changes. Otherwise it holds its value, including when a pin becomes an output.
- R11: `bus_err` is high only in the cycle of `bus_req` and only for a bad access. Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read.
- R12: `pin_dir`, `irq_mask_a`, `irq_mask_b`, `sense_polar`, `sense_edge`, `sense_both` and `in_enable` carry the stored words, updated at the clock edge of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the bank |
| bus_size | input | 2 | Access size code (see R7) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read strobe |
| bus_err | output | 1 | Access error, in the strobe cycle |
| bus_err_code | output | 2 | 0 none, 1 size, 2 unmapped |
| pin_out | output | 16 | Driven pin values |
| pin_dir | output | 16 | Direction word, 1 = output |
| irq_mask_a | output | 16 | Interrupt mask A word |
| irq_mask_b | output | 16 | Interrupt mask B word |
| sense_polar | output | 16 | Polarity word |
| sense_edge | output | 16 | Edge-select word |
| sense_both | output | 16 | Both-edge word |
| in_enable | output | 16 | Input-enable word |

## Verification
The assertions assume that `bus_req` is a single-cycle strobe with address, size, direction and write data stable across that cycle, and that nothing is written while reset is low. The stimulus meets this by driving each access from the falling edge, holding it through exactly one rising edge and then dropping the strobe. It also sends reserved and oversized sizes and misaligned or out-of-window offsets only as whole strobed accesses, never as glitches on an idle bus.

// File: rtl/gpio_rb_pkg.sv
package gpio_rb_pkg;

  localparam int PORT_W       = 16;
  localparam int NUM_REGS     = 17;
  localparam int NUM_TGT      = 8;
  localparam int ALIAS_GROUPS = 3;
  localparam int SLOTS_PER_GRP = 4;
  localparam int STRIDE_LOG2  = 2;
  localparam int ALIAS_SLOTS  = ALIAS_GROUPS * SLOTS_PER_GRP;

  localparam logic [1:0] SIZE_HALF = 2'd1;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_CLEAR  = 2'd1,
    OP_SET    = 2'd2,
    OP_TOGGLE = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    T_DATA  = 3'd0,
    T_MASKA = 3'd1,
    T_MASKB = 3'd2,
    T_DIR   = 3'd3,
    T_POLAR = 3'd4,
    T_EDGE  = 3'd5,
    T_BOTH  = 3'd6,
    T_INEN  = 3'd7
  } tgt_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_SIZE = 2'd1,
    ERR_MAP  = 2'd2
  } err_e;

  // Bit operation performed on a word by one write.
  function automatic logic [PORT_W-1:0] apply_op(input logic [PORT_W-1:0] cur,
                                                 input logic [PORT_W-1:0] wval,
                                                 input op_e op);
    logic [PORT_W-1:0] res;
    case (op)
      OP_CLEAR:  res = cur & ~wval;
      OP_SET:    res = cur | wval;
      OP_TOGGLE: res = cur ^ wval;
      default:   res = wval;
    endcase
    return res;
  endfunction

  // Operation selected by a register slot number.
  function automatic op_e slot_op(input int unsigned slot);
    if (slot < ALIAS_SLOTS)
      return op_e'(2'(slot % SLOTS_PER_GRP));
    return OP_WRITE;
  endfunction

  // Storage word selected by a register slot number.
  function automatic tgt_e slot_tgt(input int unsigned slot);
    if (slot < ALIAS_SLOTS)
      return tgt_e'(3'(slot / SLOTS_PER_GRP));
    return tgt_e'(3'(slot - ALIAS_SLOTS + ALIAS_GROUPS));
  endfunction

  // Pins whose driven value must follow the new data word.
  function automatic logic [PORT_W-1:0] pin_update(input logic [PORT_W-1:0] dir_new,
                                                   input logic [PORT_W-1:0] data_old,
                                                   input logic [PORT_W-1:0] data_new);
    return dir_new & (data_old ^ data_new);
  endfunction

endpackage

// File: rtl/gpio_rb_decode.sv
module gpio_rb_decode
  import gpio_rb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output tgt_e              tgt,
  output op_e               op,
  output err_e              err
);

  localparam int IDX_W = ADDR_W - STRIDE_LOG2;

  logic [IDX_W-1:0] slot;
  logic             size_bad;
  logic             map_bad;
  int unsigned      slot_u;

  assign slot     = addr[ADDR_W-1:STRIDE_LOG2];
  assign slot_u   = 32'(slot);
  assign size_bad = (size != SIZE_HALF);
  assign map_bad  = (addr[STRIDE_LOG2-1:0] != '0) || (slot_u >= NUM_REGS);

  always_comb begin
    if (size_bad)     err = ERR_SIZE;
    else if (map_bad) err = ERR_MAP;
    else              err = ERR_NONE;
    tgt = map_bad ? T_DATA : slot_tgt(slot_u);
    op  = map_bad ? OP_WRITE : slot_op(slot_u);
  end

endmodule

// File: rtl/gpio_rb_regs.sv
module gpio_rb_regs
  import gpio_rb_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  tgt_e                            tgt,
  input  op_e                             op,
  input  logic [PORT_W-1:0]               wdata,
  output logic [NUM_TGT-1:0][PORT_W-1:0]  words_q,
  output logic [NUM_TGT-1:0][PORT_W-1:0]  words_d
);

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_word
    logic              hit;
    logic [PORT_W-1:0] q;

    assign hit        = wr_en && (int'(tgt) == g);
    assign words_d[g] = hit ? apply_op(q, wdata, op) : q;
    assign words_q[g] = q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= words_d[g];
    end
  end

  // R2
  alias_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (tgt >= T_DIR)) |-> (op == OP_WRITE));

  // R3
  clear_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == OP_CLEAR) |=> ((words_q[$past(tgt)] & $past(wdata)) == '0));

  // R4
  set_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == OP_SET) |=> ((words_q[$past(tgt)] & $past(wdata)) == $past(wdata)));

  // R5
  toggle_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == OP_TOGGLE) |=>
      (words_q[$past(tgt)] == ($past(words_q[tgt]) ^ $past(wdata))));

endmodule

// File: rtl/gpio_rb_outdrv.sv
module gpio_rb_outdrv
  import gpio_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] data_q,
  input  logic [PORT_W-1:0] data_d,
  input  logic [PORT_W-1:0] dir_d,
  output logic [PORT_W-1:0] pin_out,
  output logic [PORT_W-1:0] upd
);

  logic [PORT_W-1:0] pin_q;

  assign upd     = pin_update(dir_d, data_q, data_d);
  assign pin_out = pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= (pin_q & ~upd) | (data_d & upd);
  end

  // R10
  in_pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pin_out ^ $past(pin_out)) & ~$past(dir_d)) == '0));

  // R10
  unchanged_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_q == data_d) |=> $stable(pin_out));

endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_rb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              bus_err,
  output logic [1:0]        bus_err_code,
  output logic [15:0]       pin_out,
  output logic [15:0]       pin_dir,
  output logic [15:0]       irq_mask_a,
  output logic [15:0]       irq_mask_b,
  output logic [15:0]       sense_polar,
  output logic [15:0]       sense_edge,
  output logic [15:0]       sense_both,
  output logic [15:0]       in_enable
);

  tgt_e                           acc_tgt;
  op_e                            acc_op;
  err_e                           acc_err;
  logic                           acc_ok;
  logic                           wr_en;
  logic                           rd_en;
  logic [NUM_TGT-1:0][PORT_W-1:0] words_q;
  logic [NUM_TGT-1:0][PORT_W-1:0] words_d;
  logic [PORT_W-1:0]              pin_upd;
  logic [PORT_W-1:0]              rdata_q;

  gpio_rb_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (bus_addr),
    .size (bus_size),
    .tgt  (acc_tgt),
    .op   (acc_op),
    .err  (acc_err)
  );

  assign acc_ok = (acc_err == ERR_NONE);
  assign wr_en  = bus_req && bus_we && acc_ok;
  assign rd_en  = bus_req && !bus_we;

  gpio_rb_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .tgt     (acc_tgt),
    .op      (acc_op),
    .wdata   (bus_wdata),
    .words_q (words_q),
    .words_d (words_d)
  );

  gpio_rb_outdrv u_outdrv (
    .clk     (clk),
    .rst_n   (rst_n),
    .data_q  (words_q[T_DATA]),
    .data_d  (words_d[T_DATA]),
    .dir_d   (words_d[T_DIR]),
    .pin_out (pin_out),
    .upd     (pin_upd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= acc_ok ? words_q[acc_tgt] : '0;
  end

  assign bus_rdata    = rdata_q;
  assign bus_err      = bus_req && !acc_ok;
  assign bus_err_code = bus_req ? acc_err : ERR_NONE;

  assign pin_dir     = words_q[T_DIR];
  assign irq_mask_a  = words_q[T_MASKA];
  assign irq_mask_b  = words_q[T_MASKB];
  assign sense_polar = words_q[T_POLAR];
  assign sense_edge  = words_q[T_EDGE];
  assign sense_both  = words_q[T_BOTH];
  assign in_enable   = words_q[T_INEN];

  // R7
  size_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_size != SIZE_HALF) |-> (bus_err_code == ERR_SIZE));

  // R11
  err_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |-> !bus_err);

  // R9
  bad_write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_err) |=> $stable(words_q));

  // R9
  bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_err) |=> (bus_rdata == '0));

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> $stable(bus_rdata));

  // R10
  pin_only_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_upd & ~words_d[T_DIR]) == '0);

endmodule

// File: tb/gpio_regbank_tb.sv
module gpio_regbank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [1:0]  bus_size = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_err;
  logic [1:0]  bus_err_code;
  logic [15:0] pin_out, pin_dir, irq_mask_a, irq_mask_b;
  logic [15:0] sense_polar, sense_edge, sense_both, in_enable;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_regbank #(.ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .bus_err_code(bus_err_code),
    .pin_out(pin_out), .pin_dir(pin_dir), .irq_mask_a(irq_mask_a),
    .irq_mask_b(irq_mask_b), .sense_polar(sense_polar), .sense_edge(sense_edge),
    .sense_both(sense_both), .in_enable(in_enable)
  );

  // {we, addr, size, wdata, expected read data, expected error code}
  localparam int NV = 37;
  localparam logic [44:0] VEC [NV] = '{
    {1'b1, 8'h30, 2'd1, 16'h00F0, 16'h0000, 2'd0},
    {1'b0, 8'h30, 2'd1, 16'h0000, 16'h00F0, 2'd0},
    {1'b1, 8'h00, 2'd1, 16'h1234, 16'h0000, 2'd0},
    {1'b0, 8'h00, 2'd1, 16'h0000, 16'h1234, 2'd0},
    {1'b1, 8'h04, 2'd1, 16'h0204, 16'h0000, 2'd0},
    {1'b0, 8'h04, 2'd1, 16'h0000, 16'h1030, 2'd0},
    {1'b1, 8'h08, 2'd1, 16'h0101, 16'h0000, 2'd0},
    {1'b0, 8'h08, 2'd1, 16'h0000, 16'h1131, 2'd0},
    {1'b1, 8'h0C, 2'd1, 16'h1001, 16'h0000, 2'd0},
    {1'b0, 8'h0C, 2'd1, 16'h0000, 16'h0130, 2'd0},
    {1'b1, 8'h10, 2'd1, 16'hA5A5, 16'h0000, 2'd0},
    {1'b1, 8'h14, 2'd1, 16'h00FF, 16'h0000, 2'd0},
    {1'b1, 8'h18, 2'd1, 16'h000F, 16'h0000, 2'd0},
    {1'b1, 8'h1C, 2'd1, 16'hFFFF, 16'h0000, 2'd0},
    {1'b0, 8'h14, 2'd1, 16'h0000, 16'h5AF0, 2'd0},
    {1'b1, 8'h20, 2'd1, 16'h0F0F, 16'h0000, 2'd0},
    {1'b1, 8'h2C, 2'd1, 16'h00FF, 16'h0000, 2'd0},
    {1'b1, 8'h24, 2'd1, 16'h0F00, 16'h0000, 2'd0},
    {1'b1, 8'h28, 2'd1, 16'h8000, 16'h0000, 2'd0},
    {1'b0, 8'h2C, 2'd1, 16'h0000, 16'h80F0, 2'd0},
    {1'b1, 8'h34, 2'd1, 16'h1111, 16'h0000, 2'd0},
    {1'b1, 8'h38, 2'd1, 16'h2222, 16'h0000, 2'd0},
    {1'b1, 8'h3C, 2'd1, 16'h4444, 16'h0000, 2'd0},
    {1'b1, 8'h40, 2'd1, 16'h8888, 16'h0000, 2'd0},
    {1'b0, 8'h34, 2'd1, 16'h0000, 16'h1111, 2'd0},
    {1'b0, 8'h38, 2'd1, 16'h0000, 16'h2222, 2'd0},
    {1'b0, 8'h3C, 2'd1, 16'h0000, 16'h4444, 2'd0},
    {1'b0, 8'h40, 2'd1, 16'h0000, 16'h8888, 2'd0},
    {1'b1, 8'h44, 2'd1, 16'hFFFF, 16'h0000, 2'd2},
    {1'b0, 8'h44, 2'd1, 16'h0000, 16'h0000, 2'd2},
    {1'b1, 8'h02, 2'd1, 16'hFFFF, 16'h0000, 2'd2},
    {1'b1, 8'h00, 2'd0, 16'hFFFF, 16'h0000, 2'd1},
    {1'b1, 8'h45, 2'd2, 16'hFFFF, 16'h0000, 2'd1},
    {1'b0, 8'h00, 2'd2, 16'h0000, 16'h0000, 2'd1},
    {1'b1, 8'h30, 2'd3, 16'hFFFF, 16'h0000, 2'd1},
    {1'b0, 8'h00, 2'd1, 16'h0000, 16'h0130, 2'd0},
    {1'b0, 8'h30, 2'd1, 16'h0000, 16'h00F0, 2'd0}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One strobed access; returns the error code seen in the strobe cycle
  // and the read data seen in the following cycle.
  task automatic access(input logic we, input logic [7:0] addr, input logic [1:0] sz,
                        input logic [15:0] wd, output logic [1:0] code,
                        output logic [15:0] rd);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = addr; bus_size = sz; bus_wdata = wd;
    #1 code = bus_err_code;
    @(posedge clk);
    #1 rd = bus_rdata;
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  function automatic string vec_tag(input int i, input logic we, input logic [7:0] a,
                                    input logic [1:0] code);
    if (code == 2'd1) return "R7";
    if (code == 2'd2) return "R8";
    if (i >= 35) return "R9";
    if (!we && a < 8'h30) begin
      case (a[3:2])
        2'd1: return "R3 R6";
        2'd2: return "R4 R6";
        2'd3: return "R5 R6";
        default: return "R2";
      endcase
    end
    return "R2";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [1:0]  code;
    logic [15:0] rd;

    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 pin_out", pin_out, 16'h0);
    check("R1 pin_dir", pin_dir, 16'h0);
    check("R1 mask_a", irq_mask_a, 16'h0);
    check("R1 in_enable", in_enable, 16'h0);
    check("R1 rdata", bus_rdata, 16'h0);
    check("R1 err", {14'd0, bus_err_code}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic        v_we;
      logic [7:0]  v_addr;
      logic [1:0]  v_sz;
      logic [15:0] v_wd;
      logic [15:0] v_exp;
      logic [1:0]  v_code;
      {v_we, v_addr, v_sz, v_wd, v_exp, v_code} = VEC[i];
      access(v_we, v_addr, v_sz, v_wd, code, rd);
      check($sformatf("%s code vec%0d", (v_code == 2'd0) ? "R11" : vec_tag(i, v_we, v_addr, v_code), i),
            {14'd0, code}, {14'd0, v_code});
      if (!v_we)
        check($sformatf("%s rdata vec%0d", vec_tag(i, v_we, v_addr, v_code), i), rd, v_exp);
    end

    // R11 idle bus: no error, read data held
    @(negedge clk);
    check("R11 idle err", {15'd0, bus_err}, 16'h0);
    check("R11 rdata held", bus_rdata, 16'h00F0);

    // R12 configuration outputs follow stored words
    check("R12 pin_dir", pin_dir, 16'h00F0);
    check("R12 mask_a", irq_mask_a, 16'h5AF0);
    check("R12 mask_b", irq_mask_b, 16'h80F0);
    check("R12 polar", sense_polar, 16'h1111);
    check("R12 edge", sense_edge, 16'h2222);
    check("R12 both", sense_both, 16'h4444);
    check("R12 inen", in_enable, 16'h8888);

    // R10 only output pins whose data bit changed were driven
    check("R10 after table", pin_out, 16'h0030);

    access(1'b1, 8'h30, 2'd1, 16'h0000, code, rd);
    access(1'b1, 8'h00, 2'd1, 16'h00FF, code, rd);
    check("R10 inputs not driven", pin_out, 16'h0030);
    access(1'b1, 8'h30, 2'd1, 16'h000F, code, rd);
    check("R12 dir write timing", pin_dir, 16'h000F);
    check("R10 dir change no refresh", pin_out, 16'h0030);
    access(1'b1, 8'h04, 2'd1, 16'h0001, code, rd);
    check("R10 clear drives bit0", pin_out, 16'h0030);
    access(1'b1, 8'h08, 2'd1, 16'h0001, code, rd);
    check("R10 set drives bit0", pin_out, 16'h0031);
    access(1'b1, 8'h0C, 2'd1, 16'h0030, code, rd);
    check("R10 toggle on input pins", pin_out, 16'h0031);
    access(1'b1, 8'h00, 2'd0, 16'h0000, code, rd);
    check("R9 bad size keeps pins", pin_out, 16'h0031);
    access(1'b0, 8'h00, 2'd1, 16'h0000, code, rd);
    check("R9 bad size keeps data", rd, 16'h00CF);

    // R1 reset again clears everything
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 reset pin_out", pin_out, 16'h0);
    check("R1 reset rdata", bus_rdata, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    access(1'b0, 8'h10, 2'd1, 16'h0000, code, rd);
    check("R1 reset mask_a read", rd, 16'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule